// File: doc/BRIEF.md
# Filtered Transactional Commit Queue

This block collects the speculative stores of one transaction and keeps only those that must reach shared memory. Every incoming store carries a word address, a data word, a page-locality flag taken from address translation, and the two bounds of the running transaction's stack. A store counts as private when its page flag is set, when its address lies inside the stack window, or when its word is already marked private in this transaction. Private stores set a per-word private mark and never enter the queue. All other stores are appended in arrival order.

When the transaction commits, the queued stores are written out one per accepted transfer on a valid/ready bus write port. The private data is then committed by wiping every private mark, with no bus traffic. An abort empties the queue and wipes the marks in one cycle. Private marks live in a small direct-indexed table: the low address bits pick the entry and the upper bits are held as a tag.

The controller has three states. GATHER accepts stores. GATHER goes to REPLAY on commit and stays in GATHER on abort. REPLAY drives the bus. REPLAY goes to FINISH when the queue is empty or when its last entry is accepted. FINISH raises the done pulse and wipes the marks, then always returns to GATHER.

Top module: `fcq_commit_queue`

## Requirements
- R1: In GATHER, a store with the page flag clear, an address outside the stack window and no private mark on its word is appended to the queue, and on commit it appears on the bus with the same address and data.
- R2: A store with the page flag set is kept out of the queue. One cycle later `st_filtered` is 1, and the store is never written on the bus.
- R3: The stack window includes `stk_lo` and excludes `stk_hi`. A store at `stk_lo` or at `stk_hi-1` is private. A store at `stk_hi` or at `stk_lo-1` is queued.
- R4: A store that marks its word private sets the mark. A later store to the same word in the same transaction is also private, even with the page flag clear and the address outside the window.
- R5: On commit, queued stores are written in arrival order, one per cycle in which `bus_valid` and `bus_ready` are both high. While `bus_valid` is high and `bus_ready` is low, address and data hold.
- R6: `done` is high for exactly one cycle. That cycle follows the cycle in which the last entry is accepted. A commit with an empty queue gives `done` in the second cycle after commit is sampled, with no bus write.
- R7: After `done`, all private marks are cleared, so a store to a previously marked word with the page flag clear is queued again.
- R8: Abort in GATHER discards every queued store and clears every private mark within one cycle. Abort wins over a commit in the same cycle, and a later commit then writes nothing.
- R9: A non-local store that meets a full queue is not stored, and `overflow` rises in the next cycle. `overflow` stays high until `done` or an abort clears it. The entries already queued replay intact.
- R10: Stores, commit and abort presented during REPLAY are ignored.
- R11: After reset `bus_valid`, `done`, `overflow` and `st_filtered` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A transactional store is presented this cycle |
| st_addr | input | AW | Word address of the store |
| st_data | input | DW | Store data |
| st_page_local | input | 1 | Translation says the page is private to the thread |
| stk_lo | input | AW | Lowest stack word of the transaction (inclusive) |
| stk_hi | input | AW | Stack end bound (exclusive) |
| commit | input | 1 | Start write-out of the transaction |
| abort | input | 1 | Discard the transaction |
| bus_valid | output | 1 | A queued store is offered on the bus |
| bus_ready | input | 1 | Bus accepts the offered store |
| bus_addr | output | AW | Address of the offered store |
| bus_data | output | DW | Data of the offered store |
| done | output | 1 | One-cycle pulse when the commit has completed |
| overflow | output | 1 | Sticky: a non-local store found the queue full |
| st_filtered | output | 1 | The store of the previous cycle was classed private |

## Verification
The hardest case to reach from the ports is a store that is private only because of its mark, with neither its page flag nor the window making it so. The stimulus first marks a word with a page-local store. It then sends the same word with the flag clear from outside the window and checks that it is filtered. The bench repeats that store after a commit and after an abort to show the mark was wiped. A second hard case is a store or abort that lands in the middle of a replay. The bench holds `bus_ready` low so the controller stays in REPLAY while those inputs are presented.

// File: rtl/fcq_pkg.sv
package fcq_pkg;

    typedef enum logic [1:0] {
        FCQ_GATHER = 2'd0,
        FCQ_REPLAY = 2'd1,
        FCQ_FINISH = 2'd2
    } fcq_state_e;

endpackage

// File: rtl/fcq_window_cls.sv
module fcq_window_cls #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          page_local,
    input  logic          mark_hit,
    output logic          in_window,
    output logic          is_local
);

    // lower bound inclusive, upper bound exclusive
    always_comb begin
        in_window = (addr >= lo) && (addr < hi);
        is_local  = page_local || in_window || mark_hit;
    end

endmodule

// File: rtl/fcq_mark_table.sv
module fcq_mark_table #(
    parameter int AW      = 32,
    parameter int ENTRIES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] look_addr,
    input  logic          set_en,
    input  logic          clr_all,
    output logic          hit
);

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TW = AW - IW;

    logic [ENTRIES-1:0] valid_q;
    logic [TW-1:0]      tag_q [ENTRIES];
    logic [IW-1:0]      idx;
    logic [TW-1:0]      tag;

    assign idx = look_addr[IW-1:0];
    assign tag = look_addr[AW-1:IW];
    assign hit = valid_q[idx] && (tag_q[idx] == tag);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
            end else if (clr_all) begin
                valid_q[e] <= 1'b0;
            end else if (set_en && (idx == IW'(e))) begin
                valid_q[e] <= 1'b1;
                tag_q[e]   <= tag;
            end
        end
    end

    // R7 / R8: a wipe request leaves no marked word behind
    p_wipe_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_q == '0));

    // R4: a word that has just been marked reads back as marked
    p_mark_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all) |=> (valid_q != '0));

endmodule

// File: rtl/fcq_fifo.sv
module fcq_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    input  logic                       flush,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R9: the controller never writes into a full queue
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R5: entries are only read out while some are held
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R8: a flush leaves the queue empty
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/fcq_commit_queue.sv
module fcq_commit_queue
    import fcq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DEPTH      = 8,
    parameter int MARK_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          st_page_local,
    input  logic [AW-1:0] stk_lo,
    input  logic [AW-1:0] stk_hi,
    input  logic          commit,
    input  logic          abort,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    output logic          done,
    output logic          overflow,
    output logic          st_filtered
);

    localparam int EW = AW + DW;
    localparam int CW = $clog2(DEPTH + 1);

    fcq_state_e    state_q, state_d;

    logic          mark_hit, in_window, is_local;
    logic          take, q_push, q_pop, q_flush, ovf_set;
    logic          mark_set, mark_clr;
    logic          q_full, q_empty;
    logic [CW-1:0] q_count;
    logic [EW-1:0] q_rdata;
    logic          overflow_q, filtered_q;

    fcq_window_cls #(.AW(AW)) u_cls (
        .addr       (st_addr),
        .lo         (stk_lo),
        .hi         (stk_hi),
        .page_local (st_page_local),
        .mark_hit   (mark_hit),
        .in_window  (in_window),
        .is_local   (is_local)
    );

    fcq_mark_table #(.AW(AW), .ENTRIES(MARK_WORDS)) u_marks (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_addr  (st_addr),
        .set_en     (mark_set),
        .clr_all    (mark_clr),
        .hit        (mark_hit)
    );

    fcq_fifo #(.W(EW), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .wdata      ({st_addr, st_data}),
        .pop        (q_pop),
        .flush      (q_flush),
        .rdata      (q_rdata),
        .count      (q_count),
        .full       (q_full),
        .empty      (q_empty)
    );

    // datapath controls derived from the current state
    always_comb begin
        take     = st_valid && (state_q == FCQ_GATHER) && !abort;
        q_push   = take && !is_local && !q_full;
        ovf_set  = take && !is_local && q_full;
        mark_set = take && is_local;
        q_flush  = (state_q == FCQ_GATHER) && abort;
        mark_clr = q_flush || (state_q == FCQ_FINISH);
        q_pop    = (state_q == FCQ_REPLAY) && !q_empty && bus_ready;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FCQ_GATHER: begin
                if (abort)       state_d = FCQ_GATHER;
                else if (commit) state_d = FCQ_REPLAY;
            end
            FCQ_REPLAY: begin
                if (q_empty)                          state_d = FCQ_FINISH;
                else if (q_pop && q_count == CW'(1))  state_d = FCQ_FINISH;
            end
            FCQ_FINISH: state_d = FCQ_GATHER;
            default:    state_d = FCQ_GATHER;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FCQ_GATHER;
        else        state_q <= state_d;
    end

    // registered flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow_q <= 1'b0;
            filtered_q <= 1'b0;
        end else begin
            filtered_q <= mark_set;
            if (ovf_set)       overflow_q <= 1'b1;
            else if (mark_clr) overflow_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        bus_valid   = (state_q == FCQ_REPLAY) && !q_empty;
        bus_addr    = q_rdata[EW-1:DW];
        bus_data    = q_rdata[DW-1:0];
        done        = (state_q == FCQ_FINISH);
        overflow    = overflow_q;
        st_filtered = filtered_q;
    end

    // R5: an offered store is held until the bus takes it
    p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_data)));

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: a private store never reaches the queue
    p_private_kept_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && is_local) |-> !q_push);

    // R9: overflow rises only after a store met a full queue
    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(st_valid) && $past(q_full)));

    // R10: nothing enters or leaves by flush while replaying
    p_replay_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FCQ_REPLAY) |-> (!q_push && !q_flush));

    // R3: a store inside the window is always classed private
    p_window_private_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && in_window) |-> !q_push);

endmodule

// File: tb/tb_fcq_commit_queue.sv
`timescale 1ns/1ps
module tb_fcq_commit_queue;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_page_local = 1'b0;
    logic [AW-1:0] stk_lo = 32'h1000;
    logic [AW-1:0] stk_hi = 32'h1100;
    logic          commit = 1'b0;
    logic          abort = 1'b0;
    logic          bus_valid;
    logic          bus_ready = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          done;
    logic          overflow;
    logic          st_filtered;

    always #2.5 clk = ~clk;

    fcq_commit_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .MARK_WORDS(16)) dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_page_local(st_page_local), .stk_lo(stk_lo),
        .stk_hi(stk_hi), .commit(commit), .abort(abort), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_data(bus_data),
        .done(done), .overflow(overflow), .st_filtered(st_filtered)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } exp_t;

    exp_t   exp_q[$];
    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    longint acc_cyc = 0;
    int     nwr = 0;
    int     ready_mode = 0;
    logic [7:0] lfsr = 8'h5A;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bus_ready <= (ready_mode == 0) ? 1'b1 : ((ready_mode == 1) ? lfsr[0] : 1'b0);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every accepted bus transfer
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && bus_valid && bus_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected bus write", bus_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(bus_addr == e.a, "R5", "replay address", bus_addr, e.a);
                    chk(bus_data == e.d, "R1", "replay data", bus_data, e.d);
                end
                nwr++;
                acc_cyc = cyc;
            end
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit pg, input bit exp_local, input bit exp_queued,
                            input string req);
        exp_t e;
        st_valid = 1'b1; st_addr = a; st_data = d; st_page_local = pg;
        @(negedge clk);
        st_valid = 1'b0; st_page_local = 1'b0;
        #1;
        chk(st_filtered == exp_local, req, "filtered flag", st_filtered, exp_local);
        if (exp_queued) begin
            e.a = a; e.d = d;
            exp_q.push_back(e);
        end
    endtask

    task automatic start_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        #1;
    endtask

    task automatic wait_done(input string req, input int n0, input int w0);
        bit     seen = 0;
        longint dc = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            #1;
            if (done) begin
                seen = 1;
                dc = cyc;
            end
        end
        chk(seen, req, "done seen", seen, 1);
        chk(nwr - w0 == n0, req, "bus write count", nwr - w0, n0);
        chk(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
        if (n0 > 0) chk(dc == acc_cyc + 1, "R6", "done after last accept", dc, acc_cyc + 1);
        @(negedge clk);
        #1;
        chk(!done, "R6", "done one cycle", done, 0);
    endtask

    task automatic do_commit(input string req);
        int n0 = exp_q.size();
        int w0 = nwr;
        start_commit();
        wait_done(req, n0, w0);
    endtask

    task automatic do_abort();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        #1;
        exp_q.delete();
    endtask

    initial begin
        wait (cyc > 60000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        int w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk(!bus_valid, "R11", "bus_valid after reset", bus_valid, 0);
        chk(!done, "R11", "done after reset", done, 0);
        chk(!overflow, "R11", "overflow after reset", overflow, 0);
        chk(!st_filtered, "R11", "filtered after reset", st_filtered, 0);

        // R1 plain stores, full-rate replay in order
        do_store(32'h200, 32'hA0, 0, 0, 1, "R1");
        do_store(32'h201, 32'hA1, 0, 0, 1, "R1");
        do_store(32'h202, 32'hA2, 0, 0, 1, "R1");
        do_commit("R1");

        // R2 page-local store filtered, neighbour queued
        do_store(32'h20, 32'hB0, 1, 1, 0, "R2");
        do_store(32'h30, 32'hB1, 0, 0, 1, "R2");
        do_commit("R2");

        // R3 window edges, with a stalling bus (R5)
        ready_mode = 1;
        do_store(32'h1000, 32'hC0, 0, 1, 0, "R3");
        do_store(32'h10FF, 32'hC1, 0, 1, 0, "R3");
        do_store(32'h1100, 32'hC2, 0, 0, 1, "R3");
        do_store(32'h0FFF, 32'hC3, 0, 0, 1, "R3");
        do_store(32'h400, 32'hC4, 0, 0, 1, "R5");
        do_commit("R5");
        ready_mode = 0;

        // R4 mark makes the repeat store private; empty commit (R6)
        do_store(32'h44, 32'hD0, 1, 1, 0, "R4");
        do_store(32'h44, 32'hD1, 0, 1, 0, "R4");
        do_commit("R6");

        // R7 mark wiped by commit
        do_store(32'h44, 32'hD2, 0, 0, 1, "R7");
        do_commit("R7");

        // R8 abort discards queue and marks
        do_store(32'h55, 32'hE0, 1, 1, 0, "R8");
        do_store(32'h60, 32'hE1, 0, 0, 1, "R8");
        do_store(32'h61, 32'hE2, 0, 0, 1, "R8");
        do_abort();
        do_store(32'h55, 32'hE3, 0, 0, 1, "R8");
        do_commit("R8");

        // R8 abort wins over commit in the same cycle
        do_store(32'h70, 32'hE4, 0, 0, 1, "R8");
        abort = 1'b1; commit = 1'b1;
        @(negedge clk);
        abort = 1'b0; commit = 1'b0;
        #1;
        exp_q.delete();
        for (int i = 0; i < 4; i++) begin
            chk(!done && !bus_valid, "R8", "no replay after abort+commit", {done, bus_valid}, 0);
            @(negedge clk);
            #1;
        end
        do_commit("R8");

        // R9 overflow cleared by done, queued entries intact
        for (int i = 0; i < DEPTH; i++) do_store(32'h300 + i, 32'hF00 + i, 0, 0, 1, "R9");
        chk(!overflow, "R9", "no overflow at exactly full", overflow, 0);
        do_store(32'h3FF, 32'hFFF, 0, 0, 0, "R9");
        chk(overflow, "R9", "overflow raised", overflow, 1);
        do_commit("R9");
        chk(!overflow, "R9", "overflow cleared by done", overflow, 0);

        // R9 overflow cleared by abort
        for (int i = 0; i < DEPTH + 1; i++) do_store(32'h500 + i, 32'h5, 0, 0, i < DEPTH, "R9");
        chk(overflow, "R9", "overflow raised again", overflow, 1);
        do_abort();
        chk(!overflow, "R9", "overflow cleared by abort", overflow, 0);

        // R10 store and abort ignored during a stalled replay
        do_store(32'h600, 32'h61, 0, 0, 1, "R10");
        do_store(32'h601, 32'h62, 0, 0, 1, "R10");
        n0 = exp_q.size();
        w0 = nwr;
        ready_mode = 2;
        start_commit();
        repeat (3) @(negedge clk);
        #1;
        chk(bus_valid, "R10", "replay stalled", bus_valid, 1);
        st_valid = 1'b1; st_addr = 32'h99; st_data = 32'h99; abort = 1'b1;
        @(negedge clk);
        st_valid = 1'b0; abort = 1'b0;
        #1;
        chk(!st_filtered, "R10", "store in replay not marked", st_filtered, 0);
        chk(bus_valid && bus_addr == 32'h600, "R10", "abort ignored in replay", bus_addr, 32'h600);
        ready_mode = 0;
        wait_done("R10", n0, w0);
        do_commit("R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule